// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is a management-bus master for clause-22 PHY register access. A client places one request at a time on the request port. Each request carries a 5-bit PHY address, a 5-bit register address, a read/write flag and 16 bits of write data. The block then produces the management clock (MDC). It drives or samples the data line (MDIO) and reports completion with a one-cycle `done` strobe. For a read, the 16-bit register value appears on `rdData` together with `done`.

MDC is derived from the system clock. A parameter gives the length of each MDC half-period in system clocks. It must be chosen so that the MDC rate stays at or below 2.5 MHz. The bidirectional MDIO line is presented as three signals: a driven value, an output enable and a sampled input.

Every transaction has three parts. It opens with a long run of driven ones, then sends a command frame, then ends with a stretch where MDIO is released. In a read, that released stretch carries the turnaround, the data and a trailing idle bit. In a write, it is two idle clocks.

Top module: `mdio_master`

## Requirements
- R1: After reset, and whenever the block is not busy, `mdc`, `mdioOe`, `busy` and `done` are low.
- R2: Every transaction begins with 33 MDC periods in which `mdioOe` is high and `mdioOut` is 1.
- R3: A read then sends 16 driven bits, MSB first: `110110`, then the PHY address (MSB first), then the register address (MSB first).
- R4: After the read command, MDIO is released for 19 MDC periods. The line is sampled once in each period; call the first sample 0. `rdData` returns samples 2 to 17, with sample 2 as bit 15. Samples 0, 1 and 18 are discarded.
- R5: A write sends 32 driven bits after the preamble, MSB first: `0101`, then the PHY address, then the register address, then `10`, then the 16 write-data bits.
- R6: After the write frame, MDIO is released for exactly 2 more MDC periods before `done`.
- R7: `mdioOut` and `mdioOe` change only while MDC is low. Read samples are taken at the end of the MDC low phase, just before the rising edge.
- R8: Each MDC high and low phase lasts exactly `HALF_DIV` system clocks.
- R9: `busy` rises on the cycle after a request is accepted. It stays high until `done`, which is a single-cycle pulse seen with `busy` already low. A request presented while busy is ignored.
- R10: `done` is asserted exactly 68·2·`HALF_DIV` clocks after a read request is accepted, and 67·2·`HALF_DIV` clocks after a write request is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, accepted when not busy |
| reqWrite | input | 1 | 1 = write, 0 = read |
| phyAddr | input | 5 | Target PHY address |
| regAddr | input | 5 | Target register address |
| wrData | input | 16 | Data for a write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion strobe |
| rdData | output | 16 | Register value from the last read |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Value driven onto MDIO |
| mdioOe | output | 1 | MDIO output enable |
| mdioIn | input | 1 | Value sampled from MDIO |

## Verification
Acceptance happens at the clock edge that sees `reqValid` while the block is idle. The bench counts falling system-clock edges from that point. It expects `done` at count 68·2·`HALF_DIV` for a read and 67·2·`HALF_DIV` for a write. It also expects MDC to have been high on exactly `HALF_DIV` of those samples per MDC period.

The bench latches MDIO on every rising MDC edge and compares the captured bits against a frame it builds from the request fields. A responder in the bench changes `mdioIn` on the falling MDC edge, so each value has a full low phase of setup before the design samples it. `rdData` is compared on the cycle in which `done` is seen.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PHY_W      = 5;
  localparam int REG_W      = 5;
  localparam int DATA_W     = 16;
  localparam int PRE_BITS   = 33;
  localparam int RD_CMD     = 16;
  localparam int WR_CMD     = 32;
  localparam int RD_TAIL    = 19;
  localparam int WR_TAIL    = 2;
  localparam int FRAME_W    = WR_CMD;
  localparam int BITCNT_W   = $clog2(PRE_BITS + 1);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE,
    ST_CMD,
    ST_TAIL
  } mdioState_t;

  typedef struct packed {
    logic load;
    logic shift;
    logic sample;
    logic finish;
  } dpCtrl_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 40
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    busy,
  output logic    done,
  output logic    mdc,
  output logic    mdioOe,
  output logic    drivePre,
  output dpCtrl_t dpCtrl
);
  localparam int CNT_W = $clog2(HALF_DIV + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

  mdioState_t state;
  logic [CNT_W-1:0] phaseCnt;
  logic [BITCNT_W-1:0] bitCnt;
  logic mdcReg;
  logic opWrite;
  logic halfEnd;
  logic lastBit;
  logic accept;

  assign accept  = reqValid && (state == ST_IDLE);
  assign halfEnd = (phaseCnt == CNT_LAST);

  always_comb begin
    unique case (state)
      ST_PRE:  lastBit = (bitCnt == BITCNT_W'(PRE_BITS - 1));
      ST_CMD:  lastBit = opWrite ? (bitCnt == BITCNT_W'(WR_CMD - 1))
                                 : (bitCnt == BITCNT_W'(RD_CMD - 1));
      ST_TAIL: lastBit = opWrite ? (bitCnt == BITCNT_W'(WR_TAIL - 1))
                                 : (bitCnt == BITCNT_W'(RD_TAIL - 1));
      default: lastBit = 1'b0;
    endcase
  end

  always_comb begin
    dpCtrl.load   = accept;
    dpCtrl.shift  = halfEnd && mdcReg && (state == ST_CMD);
    dpCtrl.sample = halfEnd && !mdcReg && (state == ST_TAIL) && !opWrite;
    dpCtrl.finish = halfEnd && mdcReg && (state == ST_TAIL) && lastBit && !opWrite;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      bitCnt   <= '0;
      mdcReg   <= 1'b0;
      opWrite  <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        state    <= ST_PRE;
        phaseCnt <= '0;
        bitCnt   <= '0;
        mdcReg   <= 1'b0;
        opWrite  <= reqWrite;
      end else if (state != ST_IDLE) begin
        if (halfEnd) begin
          phaseCnt <= '0;
          mdcReg   <= ~mdcReg;
          if (mdcReg) begin
            if (lastBit) begin
              bitCnt <= '0;
              unique case (state)
                ST_PRE:  state <= ST_CMD;
                ST_CMD:  state <= ST_TAIL;
                default: begin
                  state <= ST_IDLE;
                  done  <= 1'b1;
                end
              endcase
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end else begin
          phaseCnt <= phaseCnt + 1'b1;
        end
      end
    end
  end

  assign busy     = (state != ST_IDLE);
  assign mdc      = mdcReg;
  assign mdioOe   = (state == ST_PRE) || (state == ST_CMD);
  assign drivePre = (state == ST_PRE);
endmodule

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dpCtrl,
  input  logic              reqWrite,
  input  logic [PHY_W-1:0]  phyAddr,
  input  logic [REG_W-1:0]  regAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              drivePre,
  input  logic              mdioIn,
  output logic              mdioOut,
  output logic [DATA_W-1:0] rdData
);
  logic [FRAME_W-1:0] shiftOut;
  logic [RD_TAIL-1:0] shiftIn;
  logic [FRAME_W-1:0] rdFrame;
  logic [FRAME_W-1:0] wrFrame;

  assign rdFrame = {6'b110110, phyAddr, regAddr, {(FRAME_W - RD_CMD){1'b0}}};
  assign wrFrame = {4'b0101, phyAddr, regAddr, 2'b10, wrData};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftOut <= '0;
      shiftIn  <= '0;
      rdData   <= '0;
    end else begin
      if (dpCtrl.load) begin
        shiftOut <= reqWrite ? wrFrame : rdFrame;
      end else if (dpCtrl.shift) begin
        shiftOut <= {shiftOut[FRAME_W-2:0], 1'b0};
      end
      if (dpCtrl.sample) begin
        shiftIn <= {shiftIn[RD_TAIL-2:0], mdioIn};
      end
      if (dpCtrl.finish) begin
        rdData <= shiftIn[RD_TAIL-3:RD_TAIL-2-DATA_W];
      end
    end
  end

  assign mdioOut = drivePre ? 1'b1 : shiftOut[FRAME_W-1];
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 40
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [4:0]  phyAddr,
  input  logic [4:0]  regAddr,
  input  logic [15:0] wrData,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  dpCtrl_t dpCtrl;
  logic    drivePre;

  mdio_ctrl #(.HALF_DIV(HALF_DIV)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .busy     (busy),
    .done     (done),
    .mdc      (mdc),
    .mdioOe   (mdioOe),
    .drivePre (drivePre),
    .dpCtrl   (dpCtrl)
  );

  mdio_dp uDp (
    .clk      (clk),
    .rstN     (rstN),
    .dpCtrl   (dpCtrl),
    .reqWrite (reqWrite),
    .phyAddr  (phyAddr),
    .regAddr  (regAddr),
    .wrData   (wrData),
    .drivePre (drivePre),
    .mdioIn   (mdioIn),
    .mdioOut  (mdioOut),
    .rdData   (rdData)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int HALF_DIV = 40
) (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic done,
  input logic mdc,
  input logic mdioOut,
  input logic mdioOe
);
  logic [15:0] highLen;

  always_ff @(posedge clk) begin
    if (!rstN) highLen <= '0;
    else if (mdc) highLen <= highLen + 1'b1;
    else highLen <= '0;
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdc && !mdioOe));

  // R7
  mdio_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mdc && $past(mdc)) |-> ($stable(mdioOut) && $stable(mdioOe)));

  // R8
  mdc_high_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(mdc) |-> (highLen == 16'(HALF_DIV)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R9
  busy_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);
endmodule

bind mdio_master mdio_master_chk #(.HALF_DIV(HALF_DIV)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .busy    (busy),
  .done    (done),
  .mdc     (mdc),
  .mdioOut (mdioOut),
  .mdioOe  (mdioOe)
);

// File: tb/sim_mdio_master.sv
`timescale 1ns/1ps
module sim_mdio_master;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [4:0]  phyAddr = '0;
  logic [4:0]  regAddr = '0;
  logic [15:0] wrData = '0;
  logic        busy, done, mdc, mdioOut, mdioOe;
  logic [15:0] rdData;
  logic        mdioIn = 1'b1;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  mdio_master #(.HALF_DIV(HALF)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .phyAddr(phyAddr), .regAddr(regAddr), .wrData(wrData),
    .busy(busy), .done(done), .rdData(rdData),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  logic        capOe  [0:79];
  logic        capOut [0:79];
  int          nRise = 0;
  logic [18:0] resp = '1;

  always @(posedge mdc) begin
    if (nRise < 80) begin
      capOe[nRise]  = mdioOe;
      capOut[nRise] = mdioOut;
    end
    nRise = nRise + 1;
  end

  always @(negedge mdc) begin
    if (nRise >= 49 && nRise < 68) mdioIn = resp[18 - (nRise - 49)];
    else mdioIn = 1'b1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic runTxn(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                        input logic [15:0] data, input bit poke);
    int nBits, cmdLen, cycles, highCyc, unstable, badPre, badCmd, badTail;
    logic prevMdc, prevOut, prevOe;
    logic [31:0] cmd;
    cmdLen = wr ? 32 : 16;
    nBits  = wr ? 67 : 68;
    cmd    = wr ? {4'b0101, phy, rg, 2'b10, data} : {16'h0, 6'b110110, phy, rg};
    resp   = {2'b10, data, 1'b1};
    nRise  = 0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; phyAddr = phy; regAddr = rg; wrData = data;
    @(negedge clk);
    reqValid = 1'b0;
    cycles = 0; highCyc = 0; unstable = 0;
    prevMdc = mdc; prevOut = mdioOut; prevOe = mdioOe;
    while (!done && cycles < 3000) begin
      @(negedge clk);
      cycles++;
      if (mdc) highCyc++;
      if (mdc && prevMdc && (mdioOut != prevOut || mdioOe != prevOe)) unstable++;
      prevMdc = mdc; prevOut = mdioOut; prevOe = mdioOe;
      if (poke && cycles == 10) begin
        reqValid = 1'b1; reqWrite = ~wr; phyAddr = ~phy; regAddr = ~rg; wrData = ~data;
      end
      if (poke && cycles == 11) reqValid = 1'b0;
    end
    check(done, "R10", "done seen", done, 1);
    check(cycles == nBits * 2 * HALF, "R10", "clocks to done", cycles, nBits * 2 * HALF);
    check(highCyc == nBits * HALF, "R8", "mdc high clocks", highCyc, nBits * HALF);
    check(unstable == 0, "R7", "mdio changes during mdc high", unstable, 0);
    check(nRise == nBits, wr ? "R6" : "R4", "mdc periods", nRise, nBits);
    badPre = 0; badCmd = 0; badTail = 0;
    for (int i = 0; i < nBits && i < 80; i++) begin
      if (i < 33) begin
        if (!(capOe[i] && capOut[i])) badPre++;
      end else if (i < 33 + cmdLen) begin
        if (!(capOe[i] && capOut[i] == cmd[cmdLen - 1 - (i - 33)])) badCmd++;
      end else begin
        if (capOe[i]) badTail++;
      end
    end
    check(badPre == 0, "R2", "preamble bit errors", badPre, 0);
    check(badCmd == 0, wr ? "R5" : "R3", "command bit errors", badCmd, 0);
    check(badTail == 0, wr ? "R6" : "R4", "released bits driven", badTail, 0);
    if (!wr) check(rdData == data, "R4", "read data", rdData, data);
    @(negedge clk);
    check(!done && !busy, "R9", "done single pulse then idle", {done, busy}, 0);
    if (poke) begin
      repeat (20) @(negedge clk);
      check(!busy && nRise == nBits, "R9", "request while busy ignored", nRise, nBits);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !mdc && !mdioOe && !done, "R1", "reset state",
          {busy, mdc, mdioOe, done}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !mdc && !mdioOe && !done, "R1", "idle after reset",
          {busy, mdc, mdioOe, done}, 0);
    for (int p = 0; p < 32; p++) begin
      logic [15:0] d;
      d = 16'((p * 16'h1357) ^ 16'hC3A5);
      runTxn(1'b0, 5'(p), 5'((p * 13 + 7) % 32), d, 1'b0);
      runTxn(1'b1, 5'(p), 5'(p ^ 21), ~d, 1'b0);
    end
    runTxn(1'b0, 5'd31, 5'd31, 16'hFFFF, 1'b0);
    runTxn(1'b0, 5'd0, 5'd0, 16'h0000, 1'b0);
    runTxn(1'b1, 5'd31, 5'd31, 16'hFFFF, 1'b0);
    runTxn(1'b1, 5'd0, 5'd0, 16'h0000, 1'b0);
    runTxn(1'b0, 5'd10, 5'd21, 16'h8001, 1'b1);
    runTxn(1'b1, 5'd21, 5'd10, 16'h7FFE, 1'b1);
    check(!mdc && !mdioOe, "R1", "idle at end", {mdc, mdioOe}, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule